// File: doc/BRIEF.md
# Coherency Port Transaction ID Mapper

This block sits between the interconnect and a coherent slave port that accepts only a few transaction IDs. It turns 12-bit incoming AXI IDs into 3-bit outgoing IDs. The read channel and the write channel each have their own translation table. Outgoing IDs 0 and 1 belong to the processor cores and are never handed out.

Each of the outgoing slots 2 to 6 works in one of two modes. In fixed mode it serves exactly one incoming ID, with its own 2-bit page and 5-bit user override. In dynamic mode it joins a pool that is shared on a first-come, first-served basis. Slot 7 can only be dynamic. Every dynamic binding uses the channel's shared page and user values. The page picks which 1 GiB quarter of the 4 GiB space the coherent window covers.

A dynamic binding lasts while its outstanding-transaction counter is non-zero. The counter goes up on each accepted request and down on each completion returned for that outgoing ID. When no outgoing ID can take a request, the request is stalled: ready is held low. Requests from the FPGA-to-host bridge range always keep their own user sideband.

Top module: `cohport_idmap`

## Requirements
- R1: After reset, slot 2 is fixed to incoming ID 0x004 with page 0 and user 0 on both channels. Slots 3 to 7 are dynamic and free, the shared dynamic page and user are 0, and cfg_err is 0.
- R2: A request whose ID equals a fixed slot's programmed ID is ready at once. It maps to that slot with the slot's own page and user, however many transactions are outstanding.
- R3: A request whose ID has neither a fixed slot nor a live dynamic binding takes the lowest-numbered free dynamic slot. It maps with the channel's shared dynamic page and user.
- R4: Each accepted dynamic request increments its slot's counter. Later requests with the same ID reuse that slot while the counter is non-zero. A completion (done_valid with done_id equal to the slot) decrements the counter, and the binding is released when the counter reaches 0.
- R5: req_ready is 0 in two cases: the request has no fixed slot, no binding and no free dynamic slot; or its bound slot's counter is at its maximum (2^CNT_W-1).
- R6: When (req_id & 0x807) == 0x000 (the FPGA-to-host bridge range), map_user equals req_user, whatever user override is configured.
- R7: map_id is never 0 or 1. A slot configuration write (cfg_opt=0) to slot 0 or 1 has no effect and sets cfg_err to 1 in the cycle after the write.
- R8: A slot configuration write asking for fixed mode on slot 7 is rejected. cfg_err is 1 the next cycle and slot 7 stays dynamic.
- R9: The read channel (index 0, cfg_wr=0) and the write channel (index 1, cfg_wr=1) keep separate slot tables, counters and shared dynamic options.
- R10: A completion aimed at a fixed slot or an idle slot changes nothing. A configuration write with cfg_opt=1 sets only the channel's shared dynamic page and user and never raises cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Address-valid per channel (0 read, 1 write) |
| req_id | input | 2x12 | Incoming transaction ID per channel |
| req_user | input | 2x5 | Incoming user sideband per channel |
| req_ready | output | 2 | Request can be translated this cycle; 0 means stall |
| map_id | output | 2x3 | Outgoing ID |
| map_page | output | 2x2 | 1 GiB window page |
| map_user | output | 2x5 | Outgoing user sideband |
| done_valid | input | 2 | Transaction completion per channel |
| done_id | input | 2x3 | Outgoing ID that completed |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wr | input | 1 | Channel selected by the write (0 read, 1 write) |
| cfg_opt | input | 1 | 1: write shared dynamic page and user; 0: write a slot |
| cfg_slot | input | 3 | Slot addressed by a slot write |
| cfg_fixed | input | 1 | 1: fixed mode, 0: dynamic mode |
| cfg_in_id | input | 12 | Incoming ID for a fixed slot |
| cfg_page | input | 2 | Page value |
| cfg_user | input | 5 | User override value |
| cfg_err | output | 1 | Rejected configuration write, one cycle after it |

## Verification
Some properties are checked by assertions on every cycle: no accepted request maps to a reserved outgoing ID, bridge-range IDs keep their own user sideband, a fixed request for slot 7 raises the error, and the error never appears without a preceding write. Other behaviour needs the bench's sequences and its reference model, because it depends on history across many cycles. This covers the first-come order of dynamic slots, the reuse and release of bindings as completions return, stalling on pool exhaustion and counter saturation, and the independence of the two channel tables.

// File: rtl/idmap_pkg.sv
package idmap_pkg;
  localparam int unsigned IDMAP_IN_W    = 12;
  localparam int unsigned IDMAP_OUT_W   = 3;
  localparam int unsigned IDMAP_FIRST   = 2;
  localparam int unsigned IDMAP_PG_W    = 2;
  localparam int unsigned IDMAP_US_W    = 5;
  localparam int unsigned IDMAP_NCH     = 2;
endpackage

// File: rtl/idmap_slot_ctr.sv
module idmap_slot_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok;

  assign dec_ok = dec && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, inc} - {{(CNT_W-1){1'b0}}, dec_ok};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/idmap_chan.sv
module idmap_chan #(
  parameter int unsigned     IN_W      = 12,
  parameter int unsigned     OUT_W     = 3,
  parameter int unsigned     CNT_W     = 3,
  parameter int unsigned     PG_W      = 2,
  parameter int unsigned     US_W      = 5,
  parameter int unsigned     FIRST     = 2,
  parameter logic [IN_W-1:0] DBG_ID    = 'h004,
  parameter logic [IN_W-1:0] PASS_MASK = 'h807,
  parameter logic [IN_W-1:0] PASS_VAL  = 'h000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IN_W-1:0]  req_id,
  input  logic [US_W-1:0]  req_user,
  output logic             req_ready,
  output logic [OUT_W-1:0] map_id,
  output logic [PG_W-1:0]  map_page,
  output logic [US_W-1:0]  map_user,
  input  logic             done_valid,
  input  logic [OUT_W-1:0] done_id,
  input  logic             cfg_slot_we,
  input  logic             cfg_opt_we,
  input  logic [OUT_W-1:0] cfg_slot,
  input  logic             cfg_fixed,
  input  logic [IN_W-1:0]  cfg_in_id,
  input  logic [PG_W-1:0]  cfg_page,
  input  logic [US_W-1:0]  cfg_user
);
  localparam int unsigned NS       = 1 << OUT_W;
  localparam int unsigned CMAX     = (1 << CNT_W) - 1;
  localparam int unsigned DBG_SLOT = FIRST;

  // slot table
  logic            fix_q [FIRST:NS-1];
  logic            fix_d [FIRST:NS-1];
  logic [IN_W-1:0] fid_q [FIRST:NS-1];
  logic [IN_W-1:0] fid_d [FIRST:NS-1];
  logic [PG_W-1:0] fpg_q [FIRST:NS-1];
  logic [PG_W-1:0] fpg_d [FIRST:NS-1];
  logic [US_W-1:0] fus_q [FIRST:NS-1];
  logic [US_W-1:0] fus_d [FIRST:NS-1];
  logic [IN_W-1:0] bid_q [FIRST:NS-1];
  logic [IN_W-1:0] bid_d [FIRST:NS-1];
  logic [PG_W-1:0] dpg_q, dpg_d;
  logic [US_W-1:0] dus_q, dus_d;

  logic [CNT_W-1:0] cnt [FIRST:NS-1];
  logic             inc [FIRST:NS-1];

  logic             fhit, bhit, frhit, bsat, accept, pass;
  logic [OUT_W-1:0] fsel, bsel, frsel, sel;

  // lookup: fixed match, then live binding, then lowest free dynamic slot
  always_comb begin
    fhit = 1'b0;  fsel  = OUT_W'(FIRST);
    bhit = 1'b0;  bsel  = OUT_W'(FIRST);
    frhit = 1'b0; frsel = OUT_W'(FIRST);
    for (int s = FIRST; s < NS; s++) begin
      if (!fhit && fix_q[s] && (fid_q[s] == req_id)) begin
        fhit = 1'b1; fsel = OUT_W'(s);
      end
      if (!bhit && !fix_q[s] && (cnt[s] != '0) && (bid_q[s] == req_id)) begin
        bhit = 1'b1; bsel = OUT_W'(s);
      end
      if (!frhit && !fix_q[s] && (cnt[s] == '0)) begin
        frhit = 1'b1; frsel = OUT_W'(s);
      end
    end
  end

  assign bsat      = (cnt[bsel] == CNT_W'(CMAX));
  assign req_ready = fhit | (bhit & ~bsat) | (~bhit & frhit);
  assign sel       = fhit ? fsel : (bhit ? bsel : frsel);
  assign accept    = req_valid & req_ready & ~fhit;
  assign pass      = ((req_id & PASS_MASK) == PASS_VAL);

  assign map_id   = sel;
  assign map_page = fhit ? fpg_q[fsel] : dpg_q;
  assign map_user = pass ? req_user : (fhit ? fus_q[fsel] : dus_q);

  for (genvar s = FIRST; s < NS; s++) begin : g_slot
    logic dec_s, clr_s;
    assign inc[s] = accept && (sel == OUT_W'(s));
    assign dec_s  = done_valid && (done_id == OUT_W'(s)) && !fix_q[s];
    assign clr_s  = cfg_slot_we && (cfg_slot == OUT_W'(s));
    idmap_slot_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(inc[s]), .dec(dec_s), .clr(clr_s), .cnt(cnt[s])
    );
  end

  // next state
  always_comb begin
    fix_d = fix_q; fid_d = fid_q; fpg_d = fpg_q; fus_d = fus_q; bid_d = bid_q;
    dpg_d = cfg_opt_we ? cfg_page : dpg_q;
    dus_d = cfg_opt_we ? cfg_user : dus_q;
    for (int s = FIRST; s < NS; s++) begin
      if (inc[s]) bid_d[s] = req_id;
      if (cfg_slot_we && (cfg_slot == OUT_W'(s))) begin
        fix_d[s] = cfg_fixed;
        fid_d[s] = cfg_in_id;
        fpg_d[s] = cfg_page;
        fus_d[s] = cfg_user;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = FIRST; s < NS; s++) begin
        fix_q[s] <= (s == DBG_SLOT);
        fid_q[s] <= (s == DBG_SLOT) ? DBG_ID : '0;
        fpg_q[s] <= '0;
        fus_q[s] <= '0;
        bid_q[s] <= '0;
      end
      dpg_q <= '0;
      dus_q <= '0;
    end else begin
      fix_q <= fix_d; fid_q <= fid_d; fpg_q <= fpg_d; fus_q <= fus_d; bid_q <= bid_d;
      dpg_q <= dpg_d;
      dus_q <= dus_d;
    end
  end
endmodule

// File: rtl/cohport_idmap.sv
module cohport_idmap
  import idmap_pkg::*;
#(
  parameter int unsigned     IN_W      = IDMAP_IN_W,
  parameter int unsigned     OUT_W     = IDMAP_OUT_W,
  parameter int unsigned     CNT_W     = 3,
  parameter int unsigned     PG_W      = IDMAP_PG_W,
  parameter int unsigned     US_W      = IDMAP_US_W,
  parameter int unsigned     FIRST     = IDMAP_FIRST,
  parameter logic [IN_W-1:0] DBG_ID    = 'h004,
  parameter logic [IN_W-1:0] PASS_MASK = 'h807,
  parameter logic [IN_W-1:0] PASS_VAL  = 'h000
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [IDMAP_NCH-1:0]                req_valid,
  input  logic [IDMAP_NCH-1:0][IN_W-1:0]      req_id,
  input  logic [IDMAP_NCH-1:0][US_W-1:0]      req_user,
  output logic [IDMAP_NCH-1:0]                req_ready,
  output logic [IDMAP_NCH-1:0][OUT_W-1:0]     map_id,
  output logic [IDMAP_NCH-1:0][PG_W-1:0]      map_page,
  output logic [IDMAP_NCH-1:0][US_W-1:0]      map_user,
  input  logic [IDMAP_NCH-1:0]                done_valid,
  input  logic [IDMAP_NCH-1:0][OUT_W-1:0]     done_id,
  input  logic                                cfg_we,
  input  logic                                cfg_wr,
  input  logic                                cfg_opt,
  input  logic [OUT_W-1:0]                    cfg_slot,
  input  logic                                cfg_fixed,
  input  logic [IN_W-1:0]                     cfg_in_id,
  input  logic [PG_W-1:0]                     cfg_page,
  input  logic [US_W-1:0]                     cfg_user,
  output logic                                cfg_err
);
  localparam int unsigned NS       = 1 << OUT_W;
  localparam int unsigned DYN_ONLY = NS - 1;

  logic cfg_bad, cfg_ok, err_q, err_d;

  assign cfg_bad = cfg_we && !cfg_opt &&
                   ((cfg_slot < OUT_W'(FIRST)) ||
                    ((cfg_slot == OUT_W'(DYN_ONLY)) && cfg_fixed));
  assign cfg_ok  = cfg_we && !cfg_opt && !cfg_bad;
  assign err_d   = cfg_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign cfg_err = err_q;

  for (genvar c = 0; c < IDMAP_NCH; c++) begin : g_ch
    logic sel_ch;
    assign sel_ch = (cfg_wr == c[0]);
    idmap_chan #(
      .IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W), .PG_W(PG_W), .US_W(US_W),
      .FIRST(FIRST), .DBG_ID(DBG_ID), .PASS_MASK(PASS_MASK), .PASS_VAL(PASS_VAL)
    ) u_chan (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid[c]), .req_id(req_id[c]), .req_user(req_user[c]),
      .req_ready(req_ready[c]), .map_id(map_id[c]), .map_page(map_page[c]),
      .map_user(map_user[c]),
      .done_valid(done_valid[c]), .done_id(done_id[c]),
      .cfg_slot_we(cfg_ok && sel_ch),
      .cfg_opt_we(cfg_we && cfg_opt && sel_ch),
      .cfg_slot(cfg_slot), .cfg_fixed(cfg_fixed), .cfg_in_id(cfg_in_id),
      .cfg_page(cfg_page), .cfg_user(cfg_user)
    );
  end
endmodule

// File: rtl/cohport_idmap_chk.sv
module cohport_idmap_chk #(
  parameter int unsigned     IN_W      = 12,
  parameter int unsigned     OUT_W     = 3,
  parameter int unsigned     US_W      = 5,
  parameter int unsigned     FIRST     = 2,
  parameter logic [IN_W-1:0] PASS_MASK = 'h807,
  parameter logic [IN_W-1:0] PASS_VAL  = 'h000
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            req_valid,
  input logic [1:0][IN_W-1:0]  req_id,
  input logic [1:0][US_W-1:0]  req_user,
  input logic [1:0]            req_ready,
  input logic [1:0][OUT_W-1:0] map_id,
  input logic [1:0][US_W-1:0]  map_user,
  input logic                  cfg_we,
  input logic                  cfg_opt,
  input logic [OUT_W-1:0]      cfg_slot,
  input logic                  cfg_fixed,
  input logic                  cfg_err
);
  localparam int unsigned NS = 1 << OUT_W;

  a_r7_no_reserved_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_ready[0]) |-> (map_id[0] >= OUT_W'(FIRST)));
  a_r7_no_reserved_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[1] && req_ready[1]) |-> (map_id[1] >= OUT_W'(FIRST)));
  a_r6_passthru_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && ((req_id[0] & PASS_MASK) == PASS_VAL)) |-> (map_user[0] == req_user[0]));
  a_r6_passthru_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[1] && ((req_id[1] & PASS_MASK) == PASS_VAL)) |-> (map_user[1] == req_user[1]));
  a_r8_dyn_only_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_opt && cfg_fixed && (cfg_slot == OUT_W'(NS-1))) |=> cfg_err);
  a_r7_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
endmodule

bind cohport_idmap cohport_idmap_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .US_W(US_W), .FIRST(FIRST),
  .PASS_MASK(PASS_MASK), .PASS_VAL(PASS_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_user(req_user), .req_ready(req_ready), .map_id(map_id), .map_user(map_user),
  .cfg_we(cfg_we), .cfg_opt(cfg_opt), .cfg_slot(cfg_slot), .cfg_fixed(cfg_fixed),
  .cfg_err(cfg_err)
);

// File: tb/cohport_idmap_test.sv
module cohport_idmap_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst_n;
  logic [1:0]       req_valid;
  logic [1:0][11:0] req_id;
  logic [1:0][4:0]  req_user;
  logic [1:0]       req_ready;
  logic [1:0][2:0]  map_id;
  logic [1:0][1:0]  map_page;
  logic [1:0][4:0]  map_user;
  logic [1:0]       done_valid;
  logic [1:0][2:0]  done_id;
  logic             cfg_we, cfg_wr, cfg_opt, cfg_fixed, cfg_err;
  logic [2:0]       cfg_slot;
  logic [11:0]      cfg_in_id;
  logic [1:0]       cfg_page;
  logic [4:0]       cfg_user;

  cohport_idmap uut (.*);

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  // behavioural reference
  bit mfix [2][8];
  int mfid [2][8];
  int mfpg [2][8];
  int mfus [2][8];
  int mcnt [2][8];
  int mbid [2][8];
  int mdpg [2];
  int mdus [2];
  bit merr;

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int s = 0; s < 8; s++) begin
        mfix[c][s] = (s == 2); mfid[c][s] = (s == 2) ? 'h004 : 0;
        mfpg[c][s] = 0; mfus[c][s] = 0; mcnt[c][s] = 0; mbid[c][s] = 0;
      end
      mdpg[c] = 0; mdus[c] = 0;
    end
    merr = 0;
  endtask

  function automatic void lookup(input int c, output bit rdy, output int id,
                                 output int pg, output int us);
    int f = -1; int b = -1; int fr = -1;
    for (int s = 2; s < 8; s++) begin
      if (f < 0 && mfix[c][s] && mfid[c][s] == int'(req_id[c])) f = s;
      if (b < 0 && !mfix[c][s] && mcnt[c][s] > 0 && mbid[c][s] == int'(req_id[c])) b = s;
      if (fr < 0 && !mfix[c][s] && mcnt[c][s] == 0) fr = s;
    end
    rdy = 0; id = 0; pg = mdpg[c]; us = mdus[c];
    if (f >= 0) begin rdy = 1; id = f; pg = mfpg[c][f]; us = mfus[c][f]; end
    else if (b >= 0) begin rdy = (mcnt[c][b] < 7); id = b; end
    else if (fr >= 0) begin rdy = 1; id = fr; end
    if ((req_id[c] & 12'h807) == 12'h000) us = int'(req_user[c]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit rdy; int id, pg, us;
      for (int c = 0; c < 2; c++) begin
        lookup(c, rdy, id, pg, us);
        if (req_valid[c] && rdy && !mfix[c][id]) begin
          mcnt[c][id]++; mbid[c][id] = int'(req_id[c]);
        end
        if (done_valid[c] && done_id[c] >= 2 && !mfix[c][done_id[c]] && mcnt[c][done_id[c]] > 0)
          mcnt[c][done_id[c]]--;
      end
      merr = 0;
      if (cfg_we) begin
        if (cfg_opt) begin
          mdpg[cfg_wr] = cfg_page; mdus[cfg_wr] = cfg_user;
        end else if (cfg_slot < 2 || (cfg_slot == 7 && cfg_fixed)) merr = 1;
        else begin
          mfix[cfg_wr][cfg_slot] = cfg_fixed; mfid[cfg_wr][cfg_slot] = cfg_in_id;
          mfpg[cfg_wr][cfg_slot] = cfg_page;  mfus[cfg_wr][cfg_slot] = cfg_user;
          mcnt[cfg_wr][cfg_slot] = 0;
        end
      end
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      bit rdy; int id, pg, us;
      checks++;
      if (cfg_err !== merr) begin
        errors++; $display("FAIL %s cfg_err act %0d exp %0d", tag, cfg_err, merr);
      end
      for (int c = 0; c < 2; c++) begin
        if (req_valid[c]) begin
          lookup(c, rdy, id, pg, us);
          checks++;
          if (req_ready[c] !== rdy) begin
            errors++;
            $display("FAIL %s ch%0d ready act %0d exp %0d", tag, c, req_ready[c], rdy);
          end else if (rdy && (int'(map_id[c]) != id || int'(map_page[c]) != pg ||
                               int'(map_user[c]) != us)) begin
            errors++;
            $display("FAIL %s ch%0d id/page/user act %0d/%0d/%0d exp %0d/%0d/%0d", tag, c,
                     map_id[c], map_page[c], map_user[c], id, pg, us);
          end
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // direct request with hard-coded expectations (-1 skips a field)
  task automatic req(input int c, input int id, input int user, input int e_rdy,
                     input int e_id, input int e_pg, input int e_us);
    req_valid[c] = 1'b1; req_id[c] = 12'(id); req_user[c] = 5'(user);
    @(negedge clk);
    checks++;
    if (int'(req_ready[c]) != e_rdy ||
        (e_rdy == 1 && e_id >= 0 && int'(map_id[c]) != e_id) ||
        (e_rdy == 1 && e_pg >= 0 && int'(map_page[c]) != e_pg) ||
        (e_rdy == 1 && e_us >= 0 && int'(map_user[c]) != e_us)) begin
      errors++;
      $display("FAIL %s direct ch%0d rdy/id/pg/us act %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
               tag, c, req_ready[c], map_id[c], map_page[c], map_user[c],
               e_rdy, e_id, e_pg, e_us);
    end
    tick();
    req_valid[c] = 1'b0;
  endtask

  task automatic done(input int c, input int id);
    done_valid[c] = 1'b1; done_id[c] = 3'(id);
    tick();
    done_valid[c] = 1'b0;
  endtask

  task automatic cfg(input int wr, input int opt, input int slot, input int fixed,
                     input int id, input int pg, input int us, input int e_err);
    cfg_we = 1'b1; cfg_wr = wr[0]; cfg_opt = opt[0]; cfg_slot = 3'(slot);
    cfg_fixed = fixed[0]; cfg_in_id = 12'(id); cfg_page = 2'(pg); cfg_user = 5'(us);
    tick();
    cfg_we = 1'b0;
    @(negedge clk);
    checks++;
    if (int'(cfg_err) != e_err) begin
      errors++; $display("FAIL %s direct cfg_err act %0d exp %0d", tag, cfg_err, e_err);
    end
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = '0; req_id = '0; req_user = '0; done_valid = '0;
    done_id = '0; cfg_we = 0; cfg_wr = 0; cfg_opt = 0; cfg_slot = '0; cfg_fixed = 0;
    cfg_in_id = '0; cfg_page = '0; cfg_user = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    tag = "R1";
    @(negedge clk); checks++;
    if (cfg_err !== 1'b0) begin errors++; $display("FAIL R1 cfg_err act %0d exp 0", cfg_err); end
    tick();
    req(0, 'h004, 3, 1, 2, 0, 0);
    req(1, 'h004, 3, 1, 2, 0, 0);

    tag = "R3";
    req(0, 'h801, 1, 1, 3, 0, 0);
    req(0, 'h802, 1, 1, 4, 0, 0);
    tag = "R4";
    req(0, 'h801, 1, 1, 3, 0, 0);
    tag = "R3";
    req(0, 'h803, 1, 1, 5, 0, 0);
    req(0, 'h805, 1, 1, 6, 0, 0);
    req(0, 'h809, 1, 1, 7, 0, 0);
    tag = "R5";
    req(0, 'h80A, 1, 0, -1, -1, -1);
    tag = "R9";
    req(1, 'h80A, 1, 1, 3, 0, 0);
    tag = "R4";
    done(0, 3);
    req(0, 'h80A, 1, 0, -1, -1, -1);
    done(0, 3);
    req(0, 'h80A, 1, 1, 3, 0, 0);

    tag = "R5";
    for (int k = 0; k < 6; k++) req(0, 'h802, 1, 1, 4, 0, 0);
    req(0, 'h802, 1, 0, -1, -1, -1);

    tag = "R10";
    cfg(0, 1, 0, 0, 0, 2, 9, 0);
    tag = "R6";
    done(0, 5);
    req(0, 'h010, 'h15, 1, 5, 2, 'h15);
    done(0, 5);
    tag = "R3";
    req(0, 'h813, 'h15, 1, 5, 2, 9);

    tag = "R2";
    cfg(1, 0, 5, 1, 'h123, 3, 7, 0);
    req(1, 'h123, 0, 1, 5, 3, 7);
    req(1, 'h123, 0, 1, 5, 3, 7);
    tag = "R9";
    done(0, 5);
    req(0, 'h123, 0, 1, 5, 2, 9);

    tag = "R7";
    cfg(0, 0, 0, 1, 'h0AA, 1, 1, 1);
    cfg(0, 0, 1, 0, 'h0AA, 1, 1, 1);
    tag = "R8";
    cfg(1, 0, 7, 1, 'h555, 1, 1, 1);
    req(1, 'h555, 0, 1, 4, 0, 0);
    cfg(1, 0, 7, 0, 0, 0, 0, 0);

    tag = "R10";
    done(1, 5);
    req(1, 'h123, 0, 1, 5, 3, 7);
    done(0, 2);
    req(0, 'h004, 0, 1, 2, 0, 0);
    done(1, 6);
    req(1, 'h666, 0, 1, 6, 0, 0);

    repeat (3) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule